// File: doc/BRIEF.md
# Nibble-Masked Byte Read-Modify-Write Unit

This unit carries out one bit-manipulation command on a single byte in memory. A command gives an opcode byte, a 4-bit immediate and a byte address. The opcode selects one of four operations (AND, OR, XOR or a flag-setting test) and which nibble of the byte the immediate lines up with. The three logic operations read the byte, change only the selected nibble and write the byte back. The test reads the byte, masks it with the placed immediate and updates the N and Z flags. It writes nothing back.

Commands arrive on a valid/ready channel. `cmd_valid` must stay high with stable fields until a cycle in which `cmd_ready` is also high. That cycle accepts the command. `cmd_ready` is high only while the unit is idle, so the unit holds back the next command until the current one has finished. The memory side is a single request channel. The unit raises `mem_valid` with an address, a direction and write data, and holds all of them until `mem_ready` is high. On a read, `mem_rdata` is sampled in the cycle in which `mem_valid` and `mem_ready` are both high. `done` pulses once per command. The N and Z flags are registered and are always visible.

Top module: `nib_rmw_unit`

## Requirements
- R1: Opcode byte encoding: 0x80 AND-low, 0x81 AND-high, 0x90 OR-low, 0x91 OR-high, 0x98 XOR-low, 0x99 XOR-high, 0x88 TEST-low, 0x89 TEST-high. Bit 0 selects the high nibble.
- R2: AND-low writes back byte & (0xF0 | imm), so the high nibble is unchanged.
- R3: AND-high writes back byte & ((imm << 4) | 0x0F), so the low nibble is unchanged.
- R4: OR and XOR write back byte op imm (low) or byte op (imm << 4) (high). The other nibble is unchanged.
- R5: AND, OR and XOR leave `flag_n` and `flag_z` unchanged.
- R6: TEST-low computes byte & imm, sets N to 0 and sets Z when the result is zero. It performs no write.
- R7: TEST-high computes byte & (imm << 4), sets N to bit 7 of the result and sets Z when the result is zero. It performs no write.
- R8: A logic command does exactly one read and then exactly one write, both at the command address. A test does exactly one read at the command address.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R10: `done` is high for exactly one cycle per accepted command. With `mem_ready` held high, `done` is seen in the third cycle after the accepting edge for both logic commands and tests. The new flags are visible in that same cycle.
- R11: An opcode outside the R1 set makes no memory access and leaves the flags unchanged. `done` is seen in the first cycle after the accepting edge.
- R12: After reset, `flag_n` = 0, `flag_z` = 0, `done` = 0, `mem_valid` = 0 and `cmd_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle and able to accept a command |
| cmd_opcode | input | 8 | Operation opcode byte (R1) |
| cmd_imm | input | 4 | Immediate nibble |
| cmd_addr | input | ADDR_W | Byte address |
| mem_valid | output | 1 | Memory request active |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid when a read completes |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| done | output | 1 | One-cycle end-of-command strobe |

## Verification
The bench covers every opcode against a byte model, in three modes: with `mem_ready` held high, with random stalls, and with opcodes that the unit does not recognise. It chooses immediates and bytes that give masked results of zero and results with bit 7 set. A design that fills the wrong nibble for AND, or shifts the immediate into the wrong half, corrupts the nibble that should stay put. A design that updates flags on logic commands, or that lets N follow bit 7 on the low test, shows the wrong flags. A design that writes on a test, samples the read data while the memory is stalled, or lets the request drift during a stall leaves the wrong byte in memory or gives the wrong access counts.

// File: rtl/nib_rmw_pkg.sv
package nib_rmw_pkg;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_AND  = 3'd1,
    K_OR   = 3'd2,
    K_XOR  = 3'd3,
    K_TEST = 3'd4
  } kind_e;

  // opcode values; bit 0 picks the high nibble
  localparam logic [7:0] OPC_AND_LO  = 8'h80;
  localparam logic [7:0] OPC_AND_HI  = 8'h81;
  localparam logic [7:0] OPC_OR_LO   = 8'h90;
  localparam logic [7:0] OPC_OR_HI   = 8'h91;
  localparam logic [7:0] OPC_XOR_LO  = 8'h98;
  localparam logic [7:0] OPC_XOR_HI  = 8'h99;
  localparam logic [7:0] OPC_TEST_LO = 8'h88;
  localparam logic [7:0] OPC_TEST_HI = 8'h89;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RD   = 3'd1,
    S_WR   = 3'd2,
    S_EVAL = 3'd3,
    S_FIN  = 3'd4
  } state_e;

endpackage

// File: rtl/nib_rmw_decode.sv
module nib_rmw_decode
  import nib_rmw_pkg::*;
(
  input  logic [7:0] opcode,
  output kind_e      kind,
  output logic       hi_sel
);

  always_comb begin
    kind   = K_NONE;
    hi_sel = 1'b0;
    unique case (opcode)
      OPC_AND_LO:  kind = K_AND;
      OPC_AND_HI:  begin kind = K_AND;  hi_sel = 1'b1; end
      OPC_OR_LO:   kind = K_OR;
      OPC_OR_HI:   begin kind = K_OR;   hi_sel = 1'b1; end
      OPC_XOR_LO:  kind = K_XOR;
      OPC_XOR_HI:  begin kind = K_XOR;  hi_sel = 1'b1; end
      OPC_TEST_LO: kind = K_TEST;
      OPC_TEST_HI: begin kind = K_TEST; hi_sel = 1'b1; end
      default:     begin kind = K_NONE; hi_sel = 1'b0; end
    endcase
  end

endmodule

// File: rtl/nib_rmw_alu.sv
module nib_rmw_alu
  import nib_rmw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  kind_e             kind,
  input  logic              hi_sel,
  input  logic [DATA_W/2-1:0] imm,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              test_n,
  output logic              test_z
);

  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W-1:0] placed;
  logic [DATA_W-1:0] fill;
  logic [DATA_W-1:0] masked;

  // place the immediate and build the AND fill for the other half
  generate
    if (NIB_W * 2 == DATA_W) begin : g_place
      always_comb begin
        if (hi_sel) begin
          placed = {imm, {NIB_W{1'b0}}};
          fill   = {{NIB_W{1'b0}}, {NIB_W{1'b1}}};
        end else begin
          placed = {{NIB_W{1'b0}}, imm};
          fill   = {{NIB_W{1'b1}}, {NIB_W{1'b0}}};
        end
      end
    end
  endgenerate

  always_comb begin
    masked = din & placed;
    unique case (kind)
      K_AND:   dout = din & (placed | fill);
      K_OR:    dout = din | placed;
      K_XOR:   dout = din ^ placed;
      default: dout = din;
    endcase
    test_n = masked[DATA_W-1];
    test_z = (masked == '0);
  end

  // the nibble not addressed must survive any logic operation
  p_and_low_keeps_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_AND && !hi_sel) |-> (dout[DATA_W-1:NIB_W] == din[DATA_W-1:NIB_W]));
  p_and_high_keeps_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_AND && hi_sel) |-> (dout[NIB_W-1:0] == din[NIB_W-1:0]));
  p_or_only_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_OR) |-> ((dout & din) == din));

endmodule

// File: rtl/nib_rmw_seq.sv
module nib_rmw_seq
  import nib_rmw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cmd_valid,
  input  kind_e  new_kind,
  input  kind_e  cur_kind,
  input  logic   mem_ready,
  output logic   cmd_ready,
  output logic   accept,
  output logic   mem_valid,
  output logic   mem_we,
  output logic   cap_en,
  output logic   flag_en,
  output logic   done
);

  state_e state_q, state_d;

  always_comb begin
    cmd_ready = (state_q == S_IDLE);
    accept    = cmd_ready && cmd_valid;
    mem_valid = (state_q == S_RD) || (state_q == S_WR);
    mem_we    = (state_q == S_WR);
    cap_en    = (state_q == S_RD) && mem_ready;
    flag_en   = (state_q == S_EVAL);
    done      = (state_q == S_FIN);
    state_d   = state_q;
    unique case (state_q)
      S_IDLE: if (accept) state_d = (new_kind == K_NONE) ? S_FIN : S_RD;
      S_RD:   if (mem_ready) state_d = (cur_kind == K_TEST) ? S_EVAL : S_WR;
      S_WR:   if (mem_ready) state_d = S_FIN;
      S_EVAL: state_d = S_FIN;
      S_FIN:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  p_test_never_writes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_kind == K_TEST) |-> !(mem_valid && mem_we));
  p_unknown_no_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_kind == K_NONE) |-> !mem_valid);
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_write_follows_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(mem_valid && !mem_we && mem_ready));

endmodule

// File: rtl/nib_rmw_unit.sv
module nib_rmw_unit
  import nib_rmw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_opcode,
  input  logic [3:0]        cmd_imm,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              flag_n,
  output logic              flag_z,
  output logic              done
);

  localparam int NIB_W = DATA_W / 2;

  kind_e             dec_kind, kind_q;
  logic              dec_hi, hi_q;
  logic [NIB_W-1:0]  imm_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] byte_q;
  logic              accept, cap_en, flag_en;
  logic              t_n, t_z;
  logic [DATA_W-1:0] alu_out;

  nib_rmw_decode u_dec (
    .opcode (cmd_opcode),
    .kind   (dec_kind),
    .hi_sel (dec_hi)
  );

  nib_rmw_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .new_kind  (dec_kind),
    .cur_kind  (kind_q),
    .mem_ready (mem_ready),
    .cmd_ready (cmd_ready),
    .accept    (accept),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .cap_en    (cap_en),
    .flag_en   (flag_en),
    .done      (done)
  );

  nib_rmw_alu #(.DATA_W(DATA_W)) u_alu (
    .clk    (clk),
    .rst_n  (rst_n),
    .kind   (kind_q),
    .hi_sel (hi_q),
    .imm    (imm_q),
    .din    (byte_q),
    .dout   (alu_out),
    .test_n (t_n),
    .test_z (t_z)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= K_NONE;
      hi_q   <= 1'b0;
      imm_q  <= '0;
      addr_q <= '0;
    end else if (accept) begin
      kind_q <= dec_kind;
      hi_q   <= dec_hi;
      imm_q  <= cmd_imm[NIB_W-1:0];
      addr_q <= cmd_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      byte_q <= '0;
    else if (cap_en) byte_q <= mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else if (flag_en) begin
      flag_n <= t_n;
      flag_z <= t_z;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = alu_out;

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we)
                                   && $stable(mem_addr) && $stable(mem_wdata)));
  p_rmw_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |=> ($stable(flag_n) && $stable(flag_z)));
  p_low_test_n_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && !hi_q) |=> !flag_n);
  p_idle_no_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_valid);

endmodule

// File: tb/nib_rmw_unit_tb_top.sv
module nib_rmw_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_opcode = 8'h00;
  logic [3:0] cmd_imm = 4'h0;
  logic [7:0] cmd_addr = 8'h00;
  logic       mem_valid, mem_we;
  logic       mem_ready = 1'b1;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       flag_n, flag_z, done;

  always #5 clk = ~clk;

  nib_rmw_unit #(.ADDR_W(8), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
    .cmd_imm(cmd_imm), .cmd_addr(cmd_addr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .flag_n(flag_n), .flag_z(flag_z), .done(done)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic [7:0] last_rd_addr, last_wr_addr;
  logic [7:0] mem [256];
  bit   stall_en = 1'b0;
  bit   finished = 1'b0;

  typedef struct {
    logic [7:0] addr;
    logic [7:0] val;
    logic       n, z;
    int         rd, wr, lat;
    int         c_rd, c_wr, c_cyc;
    bit         timed;
  } exp_t;
  exp_t sb[$];

  logic exp_n = 1'b0, exp_z = 1'b0;

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
        last_wr_addr <= mem_addr;
      end else begin
        rd_cnt <= rd_cnt + 1;
        last_rd_addr <= mem_addr;
      end
    end
  end

  always @(negedge clk) mem_ready <= stall_en ? ($urandom % 3 == 0) : 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] opc, input logic [3:0] imm, input logic [7:0] addr);
    exp_t e;
    logic [7:0] placed, b;
    bit hi;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    hi = opc[0];
    placed = hi ? {imm, 4'h0} : {4'h0, imm};
    b = mem[addr];
    e.addr = addr; e.val = b; e.rd = 1; e.wr = 1; e.lat = 3;
    case (opc)
      8'h80, 8'h81: e.val = b & (placed | (hi ? 8'h0F : 8'hF0));
      8'h90, 8'h91: e.val = b | placed;
      8'h98, 8'h99: e.val = b ^ placed;
      8'h88, 8'h89: begin
        e.wr = 0;
        exp_n = hi ? ((b & placed) >> 7) : 1'b0;
        exp_z = ((b & placed) == 8'h00);
      end
      default: begin e.rd = 0; e.wr = 0; e.lat = 1; end
    endcase
    e.n = exp_n; e.z = exp_z;
    e.c_rd = rd_cnt; e.c_wr = wr_cnt; e.c_cyc = cyc;
    e.timed = !stall_en;
    sb.push_back(e);
    cmd_valid = 1'b1; cmd_opcode = opc; cmd_imm = imm; cmd_addr = addr;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R10 spurious done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(mem[e.addr] == e.val, "R2/R3/R4 byte in memory", mem[e.addr], e.val);
        chk(flag_n == e.n, "R5/R6/R7 flag_n", flag_n, e.n);
        chk(flag_z == e.z, "R5/R6/R7 flag_z", flag_z, e.z);
        chk(rd_cnt - e.c_rd == e.rd, "R8/R11 read count", rd_cnt - e.c_rd, e.rd);
        chk(wr_cnt - e.c_wr == e.wr, "R6/R8 write count", wr_cnt - e.c_wr, e.wr);
        if (e.rd == 1) chk(last_rd_addr == e.addr, "R8 read address", last_rd_addr, e.addr);
        if (e.wr == 1) chk(last_wr_addr == e.addr, "R8 write address", last_wr_addr, e.addr);
        if (e.timed) chk(cyc - e.c_cyc == e.lat, "R10/R11 latency", cyc - e.c_cyc, e.lat);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !finished) begin
      errors++; checks++;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] opl [10];
    opl = '{8'h80, 8'h81, 8'h90, 8'h91, 8'h98, 8'h99, 8'h88, 8'h89, 8'h82, 8'h00};
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
    mem[8'h10] = 8'hA5;
    mem[8'h11] = 8'h5A;
    mem[8'h12] = 8'hF3;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(cmd_ready == 1'b1, "R12 cmd_ready", cmd_ready, 1);
    chk(done == 1'b0, "R12 done", done, 0);
    chk(mem_valid == 1'b0, "R12 mem_valid", mem_valid, 0);
    chk(flag_n == 1'b0 && flag_z == 1'b0, "R12 flags", {flag_n, flag_z}, 0);
    rst_n = 1'b1;
    // R1 every opcode, R2/R3 AND masks, R4 OR/XOR, no stalls
    send(8'h80, 4'h3, 8'h10);   // A5 & F3 = A1
    send(8'h81, 4'h2, 8'h11);   // 5A & 2F = 0A
    send(8'h90, 4'hC, 8'h12);   // F3 | 0C = FF
    send(8'h91, 4'h1, 8'h20);
    send(8'h98, 4'hF, 8'h21);
    send(8'h99, 4'hF, 8'h22);
    // R6 low test nonzero and zero, R7 high test with bit 7 set and zero
    send(8'h88, 4'h1, 8'h10);
    send(8'h88, 4'h0, 8'h10);
    send(8'h89, 4'h8, 8'h10);
    send(8'h89, 4'h5, 8'h11);
    // R5 flags unchanged after logic op with N set
    send(8'h89, 4'hF, 8'h12);
    send(8'h98, 4'h6, 8'h30);
    send(8'h80, 4'h0, 8'h31);
    // R11 unrecognised opcodes
    send(8'h82, 4'hF, 8'h10);
    send(8'h00, 4'hF, 8'h11);
    send(8'h8A, 4'h0, 8'h12);
    // R9 with stalls, mixed commands
    stall_en = 1'b1;
    for (int i = 0; i < 60; i++)
      send(opl[$urandom % 10], 4'($urandom), 8'($urandom % 16 + 8'h10));
    stall_en = 1'b0;
    for (int i = 0; i < 20; i++)
      send(opl[i % 10], 4'(i * 7), 8'(i + 8'h40));
    repeat (8) @(negedge clk);
    chk(sb.size() == 0, "R10 every command got done", sb.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule